// File: doc/BRIEF.md
# Spare-Backed Virtual-Channel Arbiter Group

This block does the first allocation stage for one router input port that carries four virtual channels. Each channel presents a 20-bit request vector, one bit for each candidate output virtual channel (five output ports with four channels each). A dedicated round-robin arbiter for each channel returns a one-hot grant. The consumer of a grant signals acceptance, and only an accepted grant moves that arbiter's priority pointer.

Every arbiter, including one spare, is watched by a combinational grant checker. The checker reports three kinds of violation and latches any of them into a sticky fault flag. When a channel's arbiter is flagged, the spare arbiter serves that channel instead. The channel's request is steered to the spare, and the spare's grant is steered back to the channel. If several channels are flagged, the spare is shared round-robin among those that are requesting. A defect input per arbiter corrupts that arbiter's output in a chosen way, so the fault path can be exercised.

Top module: `vc_spare_alloc`

## Requirements
- R1: A healthy channel's grant is one-hot or zero. It is never set where that channel's request bit is low, and it is nonzero whenever the request is nonzero.
- R2: An arbiter grants the first requested index at or above its pointer, wrapping from 19 to 0.
- R3: An arbiter's pointer becomes the granted index plus one (modulo 20) at a clock edge where its grant was accepted. Otherwise the pointer holds. All pointers are 0 after reset.
- R4: Error code bits for each arbiter, combinational in the same cycle: bit 0 means a request is present but there is no grant; bit 1 means two or more grant bits are set; bit 2 means a grant bit is set where the request bit is low. Index 4 is the spare.
- R5: Any error bit sets that arbiter's fault flag at the next edge. The flag stays set until reset.
- R6: A flagged channel's own arbiter output is ignored. The channel receives the spare's grant while it owns the spare, and zero otherwise.
- R7: The spare owner is the first flagged channel with a nonzero request at or after a turn pointer, wrapping from 3 to 0; channels without a request are skipped. The turn pointer moves to owner plus one when the owner accepts a nonzero spare grant while the spare is healthy. It is 0 after reset.
- R8: With all four channel arbiters flagged, every requesting channel is still served through the spare in rotation.
- R9: While the spare's own flag is set, every flagged channel receives a zero grant.
- R10: Defect codes: 0 leaves the output unchanged, 1 forces the grant to zero, 2 replaces the grant with the request vector, and 3 rotates the correct grant up by one position (bit 19 moves to bit 0). An arbiter's pointer follows its uncorrupted choice.
- R11: During and right after reset, all grants, error bits and fault flags are zero when no request is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 4x20 | Request vector for each channel |
| accept_i | input | 4 | The channel's grant is taken this cycle |
| defect_i | input | 5x2 | Defect code for each arbiter; index 4 is the spare |
| gnt_o | output | 4x20 | Grant vector for each channel |
| err_o | output | 5x3 | Checker error bits for each arbiter |
| fault_o | output | 5 | Sticky fault flag for each arbiter |

## Verification
The first pattern holds all twenty request lines high and toggles acceptance. This shows whether the pointer walks every index in order and whether it freezes when a grant is not taken. Sparse pseudo-random requests with random acceptance, first on healthy arbiters, then with three and finally four channels flagged, separate a correct wrap-around search from an off-by-one error, and a fair spare rotation from one that starves a channel or serves a channel with no request. Single-cycle defects of each code, applied with chosen request shapes, raise exactly one error bit each. This shows that the three checker conditions are independent and that the flag persists after the defect is removed. A final defect on the spare shows that flagged channels then go quiet.

// File: rtl/vsa_pkg.sv
package vsa_pkg;
  typedef enum logic [1:0] {
    DEF_NONE  = 2'd0,
    DEF_ZERO  = 2'd1,
    DEF_ECHO  = 2'd2,
    DEF_SHIFT = 2'd3
  } defect_e;

  localparam int ERR_NOGNT = 0;
  localparam int ERR_MULTI = 1;
  localparam int ERR_STRAY = 2;
  localparam int ERR_W     = 3;
endpackage

// File: rtl/vsa_rr_arb.sv
module vsa_rr_arb #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req,
  input  logic         acc,
  input  logic [1:0]   defect,
  output logic [W-1:0] gnt
);
  import vsa_pkg::*;
  localparam int PW = (W > 1) ? $clog2(W) : 1;

  logic [PW-1:0] ptr_q;
  logic [W-1:0]  pick;

  function automatic logic [W-1:0] rr_pick(input logic [W-1:0] r, input logic [PW-1:0] p);
    logic [W-1:0] oh;
    logic found;
    int idx;
    oh = '0;
    found = 1'b0;
    for (int k = 0; k < W; k++) begin
      idx = int'(p) + k;
      if (idx >= W) idx = idx - W;
      if (!found && r[idx]) begin
        oh[idx] = 1'b1;
        found = 1'b1;
      end
    end
    return oh;
  endfunction

  function automatic logic [PW-1:0] after_pick(input logic [W-1:0] oh);
    logic [PW-1:0] np;
    np = '0;
    for (int i = 0; i < W; i++)
      if (oh[i]) np = (i == W-1) ? '0 : PW'(i + 1);
    return np;
  endfunction

  assign pick = rr_pick(req, ptr_q);

  always_comb begin
    case (defect_e'(defect))
      DEF_ZERO:  gnt = '0;
      DEF_ECHO:  gnt = req;
      DEF_SHIFT: gnt = {pick[W-2:0], pick[W-1]};
      default:   gnt = pick;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                ptr_q <= '0;
    else if (acc && (|pick))   ptr_q <= after_pick(pick);
  end

  a_r1_pick_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pick));
  a_r1_pick_subset: assert property (@(posedge clk) disable iff (!rst_n) (pick & ~req) == '0);
  a_r1_pick_live:   assert property (@(posedge clk) disable iff (!rst_n) (|req) |-> (|pick));
  a_r3_ptr_hold:    assert property (@(posedge clk) disable iff (!rst_n)
                                     !(acc && (|pick)) |=> $stable(ptr_q));
  a_r3_ptr_range:   assert property (@(posedge clk) disable iff (!rst_n) int'(ptr_q) < W);
endmodule

// File: rtl/vsa_grant_chk.sv
module vsa_grant_chk #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req,
  input  logic [W-1:0] gnt,
  output logic [2:0]   err,
  output logic         fault
);
  import vsa_pkg::*;
  logic fault_q;

  always_comb begin
    err            = '0;
    err[ERR_NOGNT] = (|req) && !(|gnt);
    err[ERR_MULTI] = $countones(gnt) > 1;
    err[ERR_STRAY] = |(gnt & ~req);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_q | (|err);
  end

  assign fault = fault_q;

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n) fault |=> fault);
  a_r5_set:    assert property (@(posedge clk) disable iff (!rst_n) (|err) |=> fault);
  a_r4_clean:  assert property (@(posedge clk) disable iff (!rst_n)
                                ($onehot(gnt) && (gnt & ~req) == '0) |-> (err == '0));
endmodule

// File: rtl/vsa_spare_ctl.sv
module vsa_spare_ctl #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  flagged,
  input  logic [N-1:0]  has_req,
  input  logic          served,
  output logic [IW-1:0] owner,
  output logic          owner_vld
);
  logic [IW-1:0] turn_q;
  logic [N-1:0]  elig;

  assign elig = flagged & has_req;

  always_comb begin
    int v;
    owner     = '0;
    owner_vld = 1'b0;
    for (int k = 0; k < N; k++) begin
      v = int'(turn_q) + k;
      if (v >= N) v = v - N;
      if (!owner_vld && elig[v]) begin
        owner     = IW'(v);
        owner_vld = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      turn_q <= '0;
    else if (served) turn_q <= (int'(owner) == N-1) ? '0 : owner + 1'b1;
  end

  a_r7_owner_ok:    assert property (@(posedge clk) disable iff (!rst_n)
                                     owner_vld |-> (flagged[owner] && has_req[owner]));
  a_r7_owner_found: assert property (@(posedge clk) disable iff (!rst_n)
                                     (|elig) |-> owner_vld);
  a_r7_turn_hold:   assert property (@(posedge clk) disable iff (!rst_n)
                                     !served |=> $stable(turn_q));
endmodule

// File: rtl/vc_spare_alloc.sv
module vc_spare_alloc #(
  parameter int NUM_VC  = 4,
  parameter int NUM_OUT = 5
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_VC-1:0][NUM_OUT*NUM_VC-1:0] req_i,
  input  logic [NUM_VC-1:0]                     accept_i,
  input  logic [NUM_VC:0][1:0]                  defect_i,
  output logic [NUM_VC-1:0][NUM_OUT*NUM_VC-1:0] gnt_o,
  output logic [NUM_VC:0][2:0]                  err_o,
  output logic [NUM_VC:0]                       fault_o
);
  localparam int LINES = NUM_OUT * NUM_VC;
  localparam int NARB  = NUM_VC + 1;
  localparam int SP    = NUM_VC;
  localparam int IW    = (NUM_VC > 1) ? $clog2(NUM_VC) : 1;

  logic [NARB-1:0][LINES-1:0] arb_req, arb_gnt;
  logic [NARB-1:0]            arb_acc, fault;
  logic [NARB-1:0][2:0]       err;
  logic [NUM_VC-1:0]          has_req;
  logic [IW-1:0]              owner;
  logic                       owner_vld, spare_served;

  always_comb begin
    for (int i = 0; i < NUM_VC; i++) begin
      has_req[i] = |req_i[i];
      arb_req[i] = req_i[i];
      arb_acc[i] = accept_i[i] & ~fault[i];
    end
    arb_req[SP] = owner_vld ? req_i[owner] : '0;
    arb_acc[SP] = owner_vld & accept_i[owner];
  end

  assign spare_served = owner_vld & accept_i[owner] & (|arb_gnt[SP]) & ~fault[SP];

  for (genvar a = 0; a < NARB; a++) begin : g_arb
    vsa_rr_arb #(.W(LINES)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(arb_req[a]), .acc(arb_acc[a]),
      .defect(defect_i[a]), .gnt(arb_gnt[a])
    );
    vsa_grant_chk #(.W(LINES)) u_chk (
      .clk(clk), .rst_n(rst_n), .req(arb_req[a]), .gnt(arb_gnt[a]),
      .err(err[a]), .fault(fault[a])
    );
  end

  vsa_spare_ctl #(.N(NUM_VC), .IW(IW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .flagged(fault[NUM_VC-1:0]), .has_req(has_req),
    .served(spare_served), .owner(owner), .owner_vld(owner_vld)
  );

  always_comb begin
    for (int i = 0; i < NUM_VC; i++) begin
      if (!fault[i])
        gnt_o[i] = arb_gnt[i];
      else if (owner_vld && int'(owner) == i && !fault[SP])
        gnt_o[i] = arb_gnt[SP];
      else
        gnt_o[i] = '0;
    end
  end

  assign err_o   = err;
  assign fault_o = fault;

  for (genvar i = 0; i < NUM_VC; i++) begin : g_sva
    a_r6_wait_idle: assert property (@(posedge clk) disable iff (!rst_n)
                                     (fault[i] && !(owner_vld && int'(owner) == i)) |-> (gnt_o[i] == '0));
    a_r9_spare_dead: assert property (@(posedge clk) disable iff (!rst_n)
                                      (fault[SP] && fault[i]) |-> (gnt_o[i] == '0));
  end
endmodule

// File: tb/tb_vc_spare_alloc.sv
module tb_vc_spare_alloc;
  localparam int NV = 4;
  localparam int L  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NV-1:0][L-1:0] req;
  logic [NV-1:0]        acc;
  logic [NV:0][1:0]     defect;
  logic [NV-1:0][L-1:0] gnt;
  logic [NV:0][2:0]     err;
  logic [NV:0]          fault;

  always #4 clk = ~clk;

  vc_spare_alloc dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .accept_i(acc), .defect_i(defect),
    .gnt_o(gnt), .err_o(err), .fault_o(fault)
  );

  int total = 0;
  int failed = 0;
  int ptr_m[NV+1];
  int turn_m;
  logic [NV:0] fault_m;
  logic [NV-1:0] served_m;
  logic [31:0] lf = 32'h1234_5678;

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ 32'hA300_0001) : (s >> 1);
  endfunction

  function automatic int first_at(input logic [L-1:0] r, input int p);
    logic [2*L-1:0] d;
    d = {r, r} >> p;
    for (int j = 0; j < L; j++) if (d[j]) return (p + j) % L;
    return -1;
  endfunction

  task automatic check(input string tag, input logic [79:0] act, input logic [79:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    logic [L-1:0] rq[NV+1];
    logic [L-1:0] raw[NV+1];
    logic [L-1:0] del[NV+1];
    logic [2:0]   e[NV+1];
    logic [NV-1:0][L-1:0] eg;
    logic [NV:0][2:0] ee;
    int own;
    int idx;
    #1;
    own = -1;
    for (int k = 0; k < NV; k++) begin
      int v;
      v = (turn_m + k) % NV;
      if (own < 0 && fault_m[v] && req[v] != 0) own = v;
    end
    for (int a = 0; a <= NV; a++) begin
      rq[a] = (a < NV) ? req[a] : ((own >= 0) ? req[own] : '0);
      idx = first_at(rq[a], ptr_m[a]);
      raw[a] = (idx < 0) ? '0 : (L'(1) << idx);
      case (defect[a])
        2'd1: del[a] = '0;
        2'd2: del[a] = rq[a];
        2'd3: del[a] = (raw[a] << 1) | (raw[a] >> (L - 1));
        default: del[a] = raw[a];
      endcase
      e[a] = {(del[a] & ~rq[a]) != 0, $countones(del[a]) > 1, (rq[a] != 0) && (del[a] == 0)};
      ee[a] = e[a];
    end
    for (int i = 0; i < NV; i++) begin
      if (!fault_m[i]) eg[i] = del[i];
      else if (own == i && !fault_m[NV]) eg[i] = del[NV];
      else eg[i] = '0;
      served_m[i] = acc[i] && (eg[i] != 0);
    end
    check(tag, 80'(gnt), 80'(eg));
    check("R4 error bits", 80'(err), 80'(ee));
    check("R5 fault flags", 80'(fault), 80'(fault_m));
    @(posedge clk);
    for (int a = 0; a < NV; a++)
      if (!fault_m[a] && acc[a] && raw[a] != 0) ptr_m[a] = ($clog2(raw[a]) + 1) % L;
    if (own >= 0 && acc[own] && raw[NV] != 0) ptr_m[NV] = ($clog2(raw[NV]) + 1) % L;
    if (own >= 0 && acc[own] && del[NV] != 0 && !fault_m[NV]) turn_m = (own + 1) % NV;
    for (int a = 0; a <= NV; a++) if (e[a] != 0) fault_m[a] = 1'b1;
    @(negedge clk);
  endtask

  task automatic rand_in(input logic [NV-1:0] keep_mask);
    for (int v = 0; v < NV; v++) begin
      logic [31:0] a;
      lf = nxt(lf); a = lf;
      lf = nxt(lf);
      if (!(keep_mask[v] && fault_m[v] && req[v] != 0 && !served_m[v]))
        req[v] = L'(a & lf & (lf >> 7));
    end
    lf = nxt(lf);
    acc = NV'(lf | (lf >> 9));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    req = '0; acc = '0; defect = '0;
    for (int a = 0; a <= NV; a++) ptr_m[a] = 0;
    turn_m = 0; fault_m = '0; served_m = '0;
    @(negedge clk);
    check("R11 reset grants", 80'(gnt), 80'(0));
    check("R11 reset flags", 80'(fault), 80'(0));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R11 after reset");

    req[0] = '1; acc = 4'b0001;
    for (int n = 0; n < 22; n++) step("R2 full-request walk");
    acc = '0;
    for (int n = 0; n < 3; n++) step("R3 pointer holds without accept");
    req[0] = 20'h80001;
    step("R2 wrap search");
    acc = 4'b0001;
    for (int n = 0; n < 3; n++) step("R3 accept advances");

    for (int n = 0; n < 300; n++) begin rand_in('0); step("R1 healthy random"); end

    acc = '0; req = '0;
    req[1] = 20'h00030; defect[1] = 2'd1;
    step("R10 defect zero");
    check("R4 bit0 on VC1", 80'(err[1]), 80'(3'b001));
    defect[1] = 2'd0;
    req[2] = 20'h00300; defect[2] = 2'd2;
    step("R10 defect echo");
    check("R5 VC1 flag sticky", 80'(fault[1]), 80'(1));
    check("R4 bit1 on VC2", 80'(err[2]), 80'(3'b010));
    defect[2] = 2'd0;
    req = '0; req[3] = 20'h00001; defect[3] = 2'd3;
    step("R10 defect shift");
    check("R4 bit2 on VC3", 80'(err[3]), 80'(3'b100));
    defect[3] = 2'd0; req = '0;
    step("R5 flags after defects");
    check("R5 three flags", 80'(fault), 80'(5'b01110));

    for (int n = 0; n < 300; n++) begin rand_in('1); step("R6 R7 spare sharing"); end

    req = '0; acc = '0; req[0] = 20'h00100; defect[0] = 2'd1;
    step("R10 defect zero VC0");
    defect[0] = 2'd0;
    for (int n = 0; n < 300; n++) begin rand_in('1); step("R8 all faulty"); end

    req = '0; acc = '0; req[0] = 20'h00004; defect[NV] = 2'd1;
    step("R9 spare defect");
    check("R4 spare bit0", 80'(err[NV]), 80'(3'b001));
    defect[NV] = 2'd0;
    for (int n = 0; n < 20; n++) begin rand_in('1); step("R9 spare flagged"); end

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule